// File: doc/BRIEF.md
# Sectored Drum Channel Controller

This block connects an I/O channel to a small set of rotating, word-addressed drum stores. The stores are modelled on chip. The channel first issues a select command that names a direction. It then supplies one 36-bit address word. The address word picks a physical drum, a logical drum within it, and a starting word. If the address is acceptable, the controller waits until the shared rotational position reaches the target word. It then moves one 36-bit word per word-time, either from the channel into the store or from the store to the channel. The transfer stops on its own at the next 2048-word sector boundary.

Problems and endings reach the channel as single-cycle disconnect pulses. One pulse carries a transmission-check flag and the other carries an end-of-file flag. On writes, the controller asks the channel for each word in advance. If it finds the one-word buffer empty when the drum needs a word, it raises an I/O-check pulse.

Top module: `drumChanCtl`

## Requirements
- R1: While reset is asserted and on the first cycle after it, every output is low and the controller is idle, so the first read or write select is acknowledged.
- R2: Select codes are `00` read, `01` write, `10` and `11` illegal. One cycle after a select, exactly one reply pulses. An illegal code always gets `selIllegal`. A read or write gets `selAck` when the controller is idle and `selBusy` otherwise.
- R3: The address word carries the physical drum in bits 32:30, the logical drum in bits 20:18 and the word address in bits 14:0. A drum number of `NUM_DRUMS` or more, a drum whose `DRUM_ENABLE` bit is clear, or a logical drum of 0 or above 6 produces a `discTrc` pulse on the cycle after the word. The controller then returns to idle with no transfer.
- R4: The rotational position is an 11-bit counter. It is 0 at reset and advances every `WORD_TIME` clocks; its first step comes `WORD_TIME` clocks after reset is released. When an address word is accepted, delta is the word address modulo 2048 minus the current position, with 2048 added when that result is 0 or negative. The first word moves on the delta-th word tick after the address cycle.
- R5: Each further word moves exactly one word-time after the previous one.
- R6: A word whose address has its low 11 bits all ones is the last word of the transfer. One word-time later, `discEof` pulses if `chConnected` is high. The controller is idle after that tick in either case.
- R7: On a write, `wordReq` pulses when the address is accepted and after every stored word except the last one of the sector. A word given on `chWrValid` during a transfer fills the one-word buffer. The buffer is cleared and marked empty when the address is accepted.
- R8: If the buffer is empty when a write word falls due while `chConnected` is high, `ioCheck` pulses and the stale buffer contents are stored anyway.
- R9: A read delivers the stored words on `rdData` with `rdValid`. Each drum keeps 2^`STORE_ADDR_BITS` words, indexed by the low bits of the linear address (logical−1)×32768 + word. Higher address bits alias onto the same cells.
- R10: `discTrc` and `discEof` never pulse together, and no end-of-record indication exists.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| selValid | input | 1 | Select command present this cycle |
| selCode | input | 2 | Select code (00 read, 01 write) |
| selAck | output | 1 | Select accepted |
| selBusy | output | 1 | Select refused, controller busy |
| selIllegal | output | 1 | Select code not supported |
| chWrValid | input | 1 | Channel word present (address word or write data) |
| chWrData | input | 36 | Channel word |
| chConnected | input | 1 | Channel still connected to the controller |
| wordReq | output | 1 | Request for the next write word |
| rdValid | output | 1 | Read word present on rdData |
| rdData | output | 36 | Word read from the drum |
| ioCheck | output | 1 | Write word was missing when due |
| discTrc | output | 1 | Disconnect with transmission-check flag |
| discEof | output | 1 | Disconnect with end-of-file flag |

## Verification
The assertions take for granted that the channel raises `selValid` only with a defined code. They also assume it sends at most one word per `wordReq`, and never on the same clock as a drum word tick. They rely on `WORD_TIME` being at least two, so that consecutive read words are always separated. The stimulus answers each write request on the cycle after the request is seen, well before the next word tick. It issues selects and address words only from an idle or freshly acknowledged controller, except where refusal is the point of the test.

// File: rtl/drumChanPkg.sv
`timescale 1ns/1ps
package drumChanPkg;
  localparam int WORD_W    = 36;
  localparam int SECT_W    = 11;          // 2048 words per sector
  localparam int WADDR_W   = 15;          // word address inside a logical drum
  localparam int FIELD_W   = 3;           // drum and logical-drum fields
  localparam int LIN_W     = FIELD_W + WADDR_W;
  localparam int LOG_DRUMS = 6;
  localparam int PHYS_LSB  = 30;
  localparam int LOG_LSB   = 18;
  localparam int DELTA_W   = SECT_W + 1;

  localparam logic [1:0] SEL_READ  = 2'b00;
  localparam logic [1:0] SEL_WRITE = 2'b01;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FIRST,
    ST_DATA,
    ST_EOS
  } ctlState_e;

  typedef struct packed {
    logic takeAddr;   // latch address, clear buffer
    logic takeData;   // load channel word into buffer
    logic storeWord;  // write buffer to drum, advance address
    logic sendWord;   // read drum word to channel, advance address
  } dpStrobe_t;
endpackage

// File: rtl/drumRotor.sv
`timescale 1ns/1ps
module drumRotor
  import drumChanPkg::*;
#(
  parameter int WORD_TIME = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              tick,
  output logic [SECT_W-1:0] pos
);
  localparam int PRE_W = (WORD_TIME > 1) ? $clog2(WORD_TIME) : 1;

  logic [PRE_W-1:0] preCnt;

  assign tick = (preCnt == PRE_W'(WORD_TIME - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      preCnt <= '0;
      pos    <= '0;
    end else if (tick) begin
      preCnt <= '0;
      pos    <= pos + 1'b1;
    end else begin
      preCnt <= preCnt + 1'b1;
    end
  end
endmodule

// File: rtl/drumData.sv
`timescale 1ns/1ps
module drumData
  import drumChanPkg::*;
#(
  parameter int         NUM_DRUMS       = 2,
  parameter logic [7:0] DRUM_ENABLE     = 8'hFF,
  parameter int         STORE_ADDR_BITS = 9
) (
  input  logic               clk,
  input  logic               rst_n,
  input  dpStrobe_t          strb,
  input  logic [WORD_W-1:0]  chWrData,
  input  logic [SECT_W-1:0]  pos,
  output logic               addrOk,
  output logic [DELTA_W-1:0] firstDelta,
  output logic               lastWord,
  output logic               bufValid,
  output logic               rdValid,
  output logic [WORD_W-1:0]  rdData
);
  localparam int DRUM_IDX_W  = (NUM_DRUMS > 1) ? $clog2(NUM_DRUMS) : 1;
  localparam int STORE_DEPTH = 1 << STORE_ADDR_BITS;

  // Address word decode
  logic [FIELD_W-1:0] physF, logF;
  logic [SECT_W-1:0]  tgtOfs;
  logic               drumOk, logOk;
  logic [LIN_W-1:0]   linNext;
  logic               unusedBits;

  assign physF   = chWrData[PHYS_LSB +: FIELD_W];
  assign logF    = chWrData[LOG_LSB +: FIELD_W];
  assign tgtOfs  = chWrData[SECT_W-1:0];
  assign drumOk  = (int'(physF) < NUM_DRUMS) && DRUM_ENABLE[physF];
  assign logOk   = (logF != '0) && (int'(logF) <= LOG_DRUMS);
  assign addrOk  = drumOk && logOk;
  assign linNext = {logF - 3'd1, chWrData[WADDR_W-1:0]};
  assign unusedBits = ^{chWrData[WORD_W-1:PHYS_LSB+FIELD_W],
                        chWrData[PHYS_LSB-1:LOG_LSB+FIELD_W],
                        chWrData[LOG_LSB-1:WADDR_W]};

  // Rotational distance to target, 1..2048 word-times
  always_comb begin
    if (tgtOfs > pos)
      firstDelta = {1'b0, tgtOfs} - {1'b0, pos};
    else
      firstDelta = {1'b0, tgtOfs} - {1'b0, pos} + DELTA_W'(1 << SECT_W);
  end

  // Transfer registers
  logic [LIN_W-1:0]      linAddr;
  logic [DRUM_IDX_W-1:0] drumSel;
  logic [WORD_W-1:0]     bufData;
  logic [STORE_ADDR_BITS-1:0] cellIdx;
  logic                  advance;

  assign cellIdx  = linAddr[STORE_ADDR_BITS-1:0];
  assign lastWord = &linAddr[SECT_W-1:0];
  assign advance  = strb.storeWord | strb.sendWord;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      linAddr  <= '0;
      drumSel  <= '0;
      bufData  <= '0;
      bufValid <= 1'b0;
    end else begin
      if (strb.takeAddr) begin
        linAddr <= linNext;
        drumSel <= physF[DRUM_IDX_W-1:0];
      end else if (advance) begin
        linAddr <= linAddr + 1'b1;
      end

      if (strb.takeAddr) begin
        bufData  <= '0;
        bufValid <= 1'b0;
      end else if (strb.takeData) begin
        bufData  <= chWrData;
        bufValid <= 1'b1;
      end else if (strb.storeWord) begin
        bufValid <= 1'b0;
      end
    end
  end

  // Drum stores, one array per physical drum
  logic [WORD_W-1:0] drumWord [NUM_DRUMS];

  for (genvar g = 0; g < NUM_DRUMS; g++) begin : gDrum
    logic [WORD_W-1:0] cells [STORE_DEPTH];
    always_ff @(posedge clk) begin
      if (strb.storeWord && (drumSel == DRUM_IDX_W'(g)))
        cells[cellIdx] <= bufData;
    end
    assign drumWord[g] = cells[cellIdx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      rdValid <= strb.sendWord;
      if (strb.sendWord) rdData <= drumWord[drumSel];
    end
  end
endmodule

// File: rtl/drumCtrl.sv
`timescale 1ns/1ps
module drumCtrl
  import drumChanPkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               selValid,
  input  logic [1:0]         selCode,
  input  logic               chWrValid,
  input  logic               chConnected,
  input  logic               tick,
  input  logic               addrOk,
  input  logic [DELTA_W-1:0] firstDelta,
  input  logic               lastWord,
  input  logic               bufValid,
  output dpStrobe_t          strb,
  output logic               selAck,
  output logic               selBusy,
  output logic               selIllegal,
  output logic               wordReq,
  output logic               ioCheck,
  output logic               discTrc,
  output logic               discEof
);
  ctlState_e          state, nState;
  logic               isWrite;
  logic               aligned;
  logic [DELTA_W-1:0] waitCnt;
  logic               rwCode, xfer;

  assign rwCode = (selCode == SEL_READ) || (selCode == SEL_WRITE);

  always_comb begin
    strb   = '0;
    nState = state;
    xfer   = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (selValid && rwCode) nState = ST_FIRST;
      end
      ST_FIRST: begin
        if (chWrValid) begin
          if (addrOk) begin
            strb.takeAddr = 1'b1;
            nState        = ST_DATA;
          end else begin
            nState = ST_IDLE;
          end
        end
      end
      ST_DATA: begin
        strb.takeData = chWrValid;
        xfer = tick && (aligned || (waitCnt == DELTA_W'(1)));
        if (xfer) begin
          strb.storeWord = isWrite;
          strb.sendWord  = !isWrite;
          if (lastWord) nState = ST_EOS;
        end
      end
      ST_EOS: begin
        if (tick) nState = ST_IDLE;
      end
      default: nState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      isWrite    <= 1'b0;
      aligned    <= 1'b0;
      waitCnt    <= '0;
      selAck     <= 1'b0;
      selBusy    <= 1'b0;
      selIllegal <= 1'b0;
      wordReq    <= 1'b0;
      ioCheck    <= 1'b0;
      discTrc    <= 1'b0;
      discEof    <= 1'b0;
    end else begin
      state      <= nState;
      selAck     <= selValid && rwCode && (state == ST_IDLE);
      selBusy    <= selValid && rwCode && (state != ST_IDLE);
      selIllegal <= selValid && !rwCode;
      if (selValid && rwCode && (state == ST_IDLE))
        isWrite <= (selCode == SEL_WRITE);

      if (strb.takeAddr) begin
        waitCnt <= firstDelta;
        aligned <= 1'b0;
      end else if (xfer) begin
        aligned <= 1'b1;
      end else if ((state == ST_DATA) && tick && !aligned) begin
        waitCnt <= waitCnt - 1'b1;
      end

      wordReq <= isWrite && (strb.takeAddr || (xfer && !lastWord));
      ioCheck <= xfer && isWrite && !bufValid && chConnected;
      discTrc <= (state == ST_FIRST) && chWrValid && !addrOk;
      discEof <= (state == ST_EOS) && tick && chConnected;
    end
  end
endmodule

// File: rtl/drumChanCtl.sv
`timescale 1ns/1ps
module drumChanCtl
  import drumChanPkg::*;
#(
  parameter int         NUM_DRUMS       = 2,
  parameter logic [7:0] DRUM_ENABLE     = 8'hFF,
  parameter int         WORD_TIME       = 10,
  parameter int         STORE_ADDR_BITS = 9
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        selValid,
  input  logic [1:0]  selCode,
  output logic        selAck,
  output logic        selBusy,
  output logic        selIllegal,
  input  logic        chWrValid,
  input  logic [35:0] chWrData,
  input  logic        chConnected,
  output logic        wordReq,
  output logic        rdValid,
  output logic [35:0] rdData,
  output logic        ioCheck,
  output logic        discTrc,
  output logic        discEof
);
  logic               tick;
  logic [SECT_W-1:0]  pos;
  dpStrobe_t          strb;
  logic               addrOk, lastWord, bufValid;
  logic [DELTA_W-1:0] firstDelta;

  drumRotor #(.WORD_TIME(WORD_TIME)) uRotor (
    .clk(clk), .rst_n(rst_n), .tick(tick), .pos(pos)
  );

  drumCtrl uCtrl (
    .clk(clk), .rst_n(rst_n), .selValid(selValid), .selCode(selCode),
    .chWrValid(chWrValid), .chConnected(chConnected), .tick(tick),
    .addrOk(addrOk), .firstDelta(firstDelta), .lastWord(lastWord),
    .bufValid(bufValid), .strb(strb), .selAck(selAck), .selBusy(selBusy),
    .selIllegal(selIllegal), .wordReq(wordReq), .ioCheck(ioCheck),
    .discTrc(discTrc), .discEof(discEof)
  );

  drumData #(
    .NUM_DRUMS(NUM_DRUMS), .DRUM_ENABLE(DRUM_ENABLE),
    .STORE_ADDR_BITS(STORE_ADDR_BITS)
  ) uData (
    .clk(clk), .rst_n(rst_n), .strb(strb), .chWrData(chWrData), .pos(pos),
    .addrOk(addrOk), .firstDelta(firstDelta), .lastWord(lastWord),
    .bufValid(bufValid), .rdValid(rdValid), .rdData(rdData)
  );
endmodule

// File: rtl/drumChanCtl_chk.sv
`timescale 1ns/1ps
module drumChanCtl_chk (
  input logic clk,
  input logic rst_n,
  input logic selValid,
  input logic selAck,
  input logic selBusy,
  input logic selIllegal,
  input logic chConnected,
  input logic wordReq,
  input logic rdValid,
  input logic ioCheck,
  input logic discTrc,
  input logic discEof
);
  a_r2_single_reply: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({selAck, selBusy, selIllegal}));

  a_r2_reply_needs_select: assert property (@(posedge clk) disable iff (!rst_n)
    (selAck || selBusy || selIllegal) |-> $past(selValid));

  a_r5_read_words_spaced: assert property (@(posedge clk) disable iff (!rst_n)
    rdValid |=> !rdValid);

  a_r6_eof_only_connected: assert property (@(posedge clk) disable iff (!rst_n)
    discEof |-> $past(chConnected));

  a_r7_no_request_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    !(wordReq && rdValid));

  a_r8_iocheck_connected: assert property (@(posedge clk) disable iff (!rst_n)
    ioCheck |-> ($past(chConnected) && !rdValid));

  a_r10_one_disconnect_flag: assert property (@(posedge clk) disable iff (!rst_n)
    !(discTrc && discEof));
endmodule

bind drumChanCtl drumChanCtl_chk uChk (
  .clk(clk), .rst_n(rst_n), .selValid(selValid), .selAck(selAck),
  .selBusy(selBusy), .selIllegal(selIllegal), .chConnected(chConnected),
  .wordReq(wordReq), .rdValid(rdValid), .ioCheck(ioCheck),
  .discTrc(discTrc), .discEof(discEof)
);

// File: tb/drumChanCtl_test.sv
`timescale 1ns/1ps
module drumChanCtl_test;
  localparam int WT   = 4;
  localparam int NDR  = 4;
  localparam int SECT = 2048;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        selValid = 1'b0;
  logic [1:0]  selCode = 2'b00;
  logic        chWrValid = 1'b0;
  logic [35:0] chWrData = '0;
  logic        chConnected = 1'b1;
  logic        selAck, selBusy, selIllegal, wordReq, rdValid, ioCheck;
  logic        discTrc, discEof;
  logic [35:0] rdData;

  always #2.5 clk = ~clk;

  drumChanCtl #(
    .NUM_DRUMS(NDR), .DRUM_ENABLE(8'b0000_0111), .WORD_TIME(WT),
    .STORE_ADDR_BITS(9)
  ) uut (
    .clk(clk), .rst_n(rst_n), .selValid(selValid), .selCode(selCode),
    .selAck(selAck), .selBusy(selBusy), .selIllegal(selIllegal),
    .chWrValid(chWrValid), .chWrData(chWrData), .chConnected(chConnected),
    .wordReq(wordReq), .rdValid(rdValid), .rdData(rdData),
    .ioCheck(ioCheck), .discTrc(discTrc), .discEof(discEof)
  );

  int cyc = 0;
  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  int  nChecks = 0;
  int  nFail   = 0;
  bit  done    = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [35:0] wpat(input int i);
    return {4'hC, 32'h5A00_0000 + 32'(i)};
  endfunction

  function automatic int expFirst(input int a, input int word);
    int cp, tgt, d, ft;
    cp  = ((a - 1) / WT) % SECT;
    tgt = word % SECT;
    d   = (tgt > cp) ? tgt - cp : tgt - cp + SECT;
    ft  = (a / WT + 1) * WT;
    return ft + (d - 1) * WT;
  endfunction

  // Monitor results
  int          reqCnt, rdCnt, iocCnt, eofCnt, trcCnt;
  int          reqCyc [4];
  int          rdCyc  [4];
  logic [35:0] rdDat  [4];
  int          iocCyc, eofCyc, trcCyc;

  // Called at a negedge; returns at a negedge
  task automatic doSelect(input logic [1:0] code, input logic [2:0] expReply,
                          input string req);
    selValid = 1'b1;
    selCode  = code;
    @(negedge clk);
    selValid = 1'b0;
    check({selAck, selBusy, selIllegal} == expReply, req, "select reply",
          {selAck, selBusy, selIllegal}, expReply);
  endtask

  task automatic sendAddr(input int phys, input int lg, input int word,
                          output int a);
    a = cyc + 1;
    chWrValid = 1'b1;
    chWrData  = {3'b0, 3'(phys), 9'b0, 3'(lg), 3'b0, 15'(word)};
  endtask

  task automatic runMon(input int stopAt, input int answer, input int base);
    int answered;
    answered = 0;
    reqCnt = 0; rdCnt = 0; iocCnt = 0; eofCnt = 0; trcCnt = 0;
    iocCyc = -1; eofCyc = -1; trcCyc = -1;
    do begin
      @(negedge clk);
      chWrValid = 1'b0;
      if (wordReq) begin
        if (reqCnt < 4) reqCyc[reqCnt] = cyc;
        reqCnt++;
        if (answered < answer) begin
          chWrValid = 1'b1;
          chWrData  = wpat(base + answered);
          answered++;
        end
      end
      if (rdValid) begin
        if (rdCnt < 4) begin
          rdCyc[rdCnt] = cyc;
          rdDat[rdCnt] = rdData;
        end
        rdCnt++;
      end
      if (ioCheck) begin iocCnt++; iocCyc = cyc; end
      if (discEof) begin eofCnt++; eofCyc = cyc; end
      if (discTrc) begin trcCnt++; trcCyc = cyc; end
    end while (cyc < stopAt);
  endtask

  task automatic tReset();
    check({selAck, selBusy, selIllegal, wordReq, rdValid, ioCheck, discTrc,
           discEof} == 8'h00, "R1", "outputs after reset",
          {selAck, selBusy, selIllegal, wordReq, rdValid, ioCheck, discTrc,
           discEof}, 0);
    check(rdData == '0, "R1", "rdData after reset", rdData, 0);
  endtask

  task automatic tIllegal();
    doSelect(2'b10, 3'b001, "R2");
    doSelect(2'b11, 3'b001, "R2");
  endtask

  task automatic tBadAddr(input int phys, input int lg, input string what);
    int a;
    doSelect(2'b00, 3'b100, "R1");
    sendAddr(phys, lg, 100, a);
    runMon(a + 3, 0, 0);
    check(trcCnt == 1 && trcCyc == a, "R3", what, trcCyc, a);
    check(rdCnt == 0 && eofCnt == 0, "R10", "no transfer after check",
          rdCnt + eofCnt, 0);
  endtask

  task automatic tBusy();
    int a;
    doSelect(2'b01, 3'b100, "R2");
    doSelect(2'b00, 3'b010, "R2");
    doSelect(2'b01, 3'b010, "R2");
    sendAddr(0, 0, 5, a);
    runMon(a + 2, 0, 0);
    check(trcCnt == 1 && reqCnt == 0, "R3", "logical 0 after busy",
          trcCnt, 1);
  endtask

  task automatic tWrite();
    int a, e;
    doSelect(2'b01, 3'b100, "R2");
    sendAddr(1, 2, 2045, a);
    e = expFirst(a, 2045);
    runMon(e + 3 * WT + 2, 3, 0);
    check(reqCnt == 3, "R7", "write request count", reqCnt, 3);
    check(reqCyc[0] == a, "R7", "request at address", reqCyc[0], a);
    check(reqCyc[1] == e, "R4", "first stored word time", reqCyc[1], e);
    check(reqCyc[2] == e + WT, "R5", "second stored word time", reqCyc[2],
          e + WT);
    check(iocCnt == 0, "R8", "no io check when fed", iocCnt, 0);
    check(eofCnt == 1 && eofCyc == e + 3 * WT, "R6", "eof after write",
          eofCyc, e + 3 * WT);
  endtask

  task automatic tRead(input int phys, input int lg, input int word,
                       input int n, input int base, input bit stale);
    int a, e;
    doSelect(2'b00, 3'b100, "R2");
    sendAddr(phys, lg, word, a);
    e = expFirst(a, word);
    runMon(e + n * WT + 2, 0, 0);
    check(rdCnt == n, "R9", "read word count", rdCnt, n);
    check(rdCyc[0] == e, "R4", "first read time", rdCyc[0], e);
    for (int i = 0; i < n; i++) begin
      check(rdDat[i] == wpat(stale ? base : base + i), "R9", "read data",
            rdDat[i], wpat(stale ? base : base + i));
      if (i > 0)
        check(rdCyc[i] == rdCyc[i-1] + WT, "R5", "read spacing", rdCyc[i],
              rdCyc[i-1] + WT);
    end
    check(eofCnt == 1 && eofCyc == e + n * WT, "R6", "eof after read",
          eofCyc, e + n * WT);
    check(reqCnt == 0, "R7", "no request on read", reqCnt, 0);
  endtask

  task automatic tIoCheck();
    int a, e;
    doSelect(2'b01, 3'b100, "R2");
    sendAddr(0, 1, 2046, a);
    e = expFirst(a, 2046);
    runMon(e + 2 * WT + 2, 1, 10);
    check(reqCnt == 2, "R7", "requests before sector end", reqCnt, 2);
    check(iocCnt == 1 && iocCyc == e + WT, "R8", "io check on empty buffer",
          iocCyc, e + WT);
    check(eofCyc == e + 2 * WT, "R6", "eof after io check", eofCyc,
          e + 2 * WT);
    tRead(0, 1, 2046, 2, 10, 1'b1);
  endtask

  task automatic tNoConn();
    int a, e;
    doSelect(2'b00, 3'b100, "R2");
    chConnected = 1'b0;
    sendAddr(1, 6, 32767, a);
    e = expFirst(a, 32767);
    runMon(e + WT + 3, 0, 0);
    check(rdCnt == 1 && rdDat[0] == wpat(2), "R9", "aliased word at top",
          rdDat[0], wpat(2));
    check(eofCnt == 0, "R6", "no eof when disconnected", eofCnt, 0);
    chConnected = 1'b1;
    doSelect(2'b00, 3'b100, "R6");
    sendAddr(7, 1, 0, a);
    runMon(a + 2, 0, 0);
  endtask

  task automatic tFullRev();
    int a, cp, word, e, n;
    doSelect(2'b00, 3'b100, "R2");
    a    = cyc + 1;
    cp   = ((a - 1) / WT) % SECT;
    word = 5 * SECT + cp;
    sendAddr(0, 4, word, a);
    e = expFirst(a, word);
    check(e == (a / WT + 1) * WT + (SECT - 1) * WT, "R4",
          "zero delta waits a revolution", e, 0);
    n = SECT - cp;
    runMon(e + n * WT + 2, 0, 0);
    check(rdCyc[0] == e, "R4", "full revolution first read", rdCyc[0], e);
    check(rdCnt == n, "R6", "words to sector end", rdCnt, n);
    check(eofCyc == e + n * WT, "R6", "eof after long read", eofCyc,
          e + n * WT);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    tReset();
    rst_n = 1'b1;
    @(negedge clk);
    tReset();
    tIllegal();
    tBadAddr(7, 1, "drum beyond count");
    tBadAddr(3, 1, "disabled drum");
    tBadAddr(0, 0, "logical zero");
    tBadAddr(1, 7, "logical seven");
    tBusy();
    tWrite();
    tRead(1, 2, 2045, 3, 0, 1'b0);
    tIoCheck();
    tNoConn();
    tFullRev();
    done = 1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog: actual %0d expected done", cyc);
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end
endmodule